// File: doc/BRIEF.md
# Masked Fixed-Priority Interrupt Controller

This block collects interrupt requests from four devices and holds each in its own sticky pending bit. A per-source mask decides which pending bits may compete. A global enable decides whether the CPU is interrupted at all. The lowest-numbered unmasked pending source wins. Its index forms the two low bits of an 8-bit vector, and the upper six bits come from a programmable base.

A single registered request line tells the CPU that an eligible source is waiting. While the CPU holds its acknowledge input high, the block drives the vector and raises an output-enable, but only if the request line and the global enable are both set. An acknowledge that is taken clears the winner's pending bit and the global enable. Software must set the enable again before the next interrupt can be recognised. Configuration uses one write port that can select the mask, the enable or the vector base.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cpu_irq_o`, `vec_oe_o` and `vec_o` are 0, every pending bit and mask bit is 0, the enable is 0 and the base is 0.
- R2: A high `dev_req_i[i]` at a clock edge sets pending bit i. The bit stays set until an acknowledge clears it. `cpu_irq_o` is high one cycle after the edge if bit i is unmasked and the enable is set.
- R3: Mask bit i at 0 excludes source i from selection and from `cpu_irq_o`. Its pending bit is kept, so writing mask bit i to 1 later makes it eligible.
- R4: Among unmasked pending sources, the lowest index wins. `vec_o[1:0]` holds the winner's index in binary.
- R5: `vec_o[7:2]` equals the last base written (select 2, taken from `cfg_wdata_i[7:2]`).
- R6: `vec_oe_o` is high exactly when `cpu_ack_i`, `cpu_irq_o` and the enable are all high. While `vec_oe_o` is low, `vec_o` is 0.
- R7: With the enable at 0 (select 1 writes `cfg_wdata_i[0]`), `cpu_irq_o` stays low and pending bits are kept.
- R8: A cycle with `vec_oe_o` high clears only the winner's pending bit and clears the enable, so `cpu_irq_o` is low in the following cycle.
- R9: If `dev_req_i[i]` is high in the same cycle that acknowledge clears bit i, the bit stays set.
- R10: An enable write in the same cycle as a taken acknowledge takes precedence over the clear. Select 0 writes the mask from `cfg_wdata_i[3:0]`, with 1 meaning enabled. Select 3 writes nothing.
- R11: An acknowledge while `vec_oe_o` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dev_req_i | input | 4 | Device request lines, sampled every edge |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 0 mask, 1 enable, 2 base, 3 none |
| cfg_wdata_i | input | 8 | Configuration write data |
| cpu_ack_i | input | 1 | Acknowledge from the CPU |
| cpu_irq_o | output | 1 | Registered request to the CPU |
| vec_o | output | 8 | Vector, zero unless enabled |
| vec_oe_o | output | 1 | Vector output-enable |

## Verification
Requests, configuration writes and acknowledge clears all take effect at the next clock edge, so `cpu_irq_o` reflects them one cycle later. `vec_oe_o` and `vec_o` are combinational from `cpu_ack_i` and registered state, so they are valid in the same cycle. The bench changes inputs 1 ns after a rising edge. It reads the combinational vector 1 ns after raising acknowledge, and it reads `cpu_irq_o` 1 ns after the edge that follows each stimulus. A sweep covers all 256 pairs of request pattern and mask. In each pair, one acknowledge is followed by unmasking all sources, and a second acknowledge shows which pending bits survived.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Targets of the configuration write port
    typedef enum logic [1:0] {
        CFG_MASK   = 2'd0,
        CFG_ENABLE = 2'd1,
        CFG_BASE   = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_sel_e;

    localparam int unsigned PIC_DEF_SRC   = 4;
    localparam int unsigned PIC_DEF_VEC_W = 8;

endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_q_o,
    output logic [NUM_SRC-1:0] pend_d_o
);

    logic [NUM_SRC-1:0] pend_d, pend_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        // A new request beats a clear so no request is dropped
        always_comb pend_d[g] = set_i[g] | (pend_q[g] & ~clr_i[g]);

        p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pend_q[g] && !clr_i[g]) |=> pend_q[g]);

        p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[g] |=> pend_q[g]);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    assign pend_q_o = pend_q;
    assign pend_d_o = pend_d;

endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] act_i,
    output logic               any_o,
    output logic [NUM_SRC-1:0] grant_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Scan from index 0 upward; the first active bit wins
    always_comb begin
        logic seen;
        seen    = 1'b0;
        grant_o = '0;
        idx_o   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act_i[i] && !seen) begin
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
            end
            seen = seen | act_i[i];
        end
        any_o = seen;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned NUM_SRC = PIC_DEF_SRC,
    parameter int unsigned VEC_W   = PIC_DEF_VEC_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] dev_req_i,
    input  logic               cfg_we_i,
    input  logic [1:0]         cfg_sel_i,
    input  logic [VEC_W-1:0]   cfg_wdata_i,
    input  logic               cpu_ack_i,
    output logic               cpu_irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               vec_oe_o
);

    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int unsigned BASE_W = VEC_W - IDX_W;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic               ien;
        logic [BASE_W-1:0]  base;
        logic               ist;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_SRC-1:0] pend_q, pend_d, active, grant, clr;
    logic [IDX_W-1:0]   win_idx;
    logic               any_act;
    logic               take;
    cfg_sel_e           sel;

    pic_req_latch #(.NUM_SRC(NUM_SRC)) i_latch (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (dev_req_i),
        .clr_i    (clr),
        .pend_q_o (pend_q),
        .pend_d_o (pend_d)
    );

    pic_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_pick (
        .act_i   (active),
        .any_o   (any_act),
        .grant_o (grant),
        .idx_o   (win_idx)
    );

    always_comb begin
        sel    = cfg_sel_e'(cfg_sel_i);
        active = pend_q & ctl_q.mask;
        take   = cpu_ack_i & ctl_q.ist & ctl_q.ien;
        clr    = take ? grant : '0;

        ctl_d = ctl_q;
        if (take) ctl_d.ien = 1'b0;
        if (cfg_we_i) begin
            unique case (sel)
                CFG_MASK:   ctl_d.mask = cfg_wdata_i[NUM_SRC-1:0];
                CFG_ENABLE: ctl_d.ien  = cfg_wdata_i[0];
                CFG_BASE:   ctl_d.base = cfg_wdata_i[VEC_W-1:IDX_W];
                default:    ;
            endcase
        end
        // Status follows the next-cycle state so it never lags a clear
        ctl_d.ist = (|(pend_d & ctl_d.mask)) & ctl_d.ien;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign cpu_irq_o = ctl_q.ist;
    assign vec_oe_o  = take;
    assign vec_o     = take ? {ctl_q.base, win_idx} : '0;

    p_irq_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_irq_o |-> (any_act && ctl_q.ien));

    p_oe_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_oe_o |-> (cpu_ack_i && cpu_irq_o));

    p_vec_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_oe_o |-> (vec_o == '0));

    p_grant_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant));

    p_lowest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_oe_o |-> (active[vec_o[IDX_W-1:0]] &&
            ((active & ((NUM_SRC'(1) << vec_o[IDX_W-1:0]) - NUM_SRC'(1))) == '0)));

    p_ack_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_oe_o && !(cfg_we_i && cfg_sel_i == 2'd1)) |=> !cpu_irq_o);

    p_ien_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctl_q.ien |-> !cpu_irq_o);

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] dev_req;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [7:0] cfg_wdata;
    logic       cpu_ack;
    logic       cpu_irq;
    logic [7:0] vec;
    logic       vec_oe;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .dev_req_i   (dev_req),
        .cfg_we_i    (cfg_we),
        .cfg_sel_i   (cfg_sel),
        .cfg_wdata_i (cfg_wdata),
        .cpu_ack_i   (cpu_ack),
        .cpu_irq_o   (cpu_irq),
        .vec_o       (vec),
        .vec_oe_o    (vec_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic cyc;
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic [1:0] s, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        cyc();
        cfg_we = 1'b0; cfg_sel = 2'd3; cfg_wdata = '0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; dev_req = '0; cfg_we = 1'b0; cfg_sel = 2'd3;
        cfg_wdata = '0; cpu_ack = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    function automatic int lowest(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return i;
        return -1;
    endfunction

    initial begin
        #(8 * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 irq", cpu_irq, 0);
        chk("R1 oe", vec_oe, 0);
        chk("R1 vec", vec, 0);

        // Sweep all request patterns against all masks
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 16; m++) begin
                logic [3:0] pv, mv, rem;
                logic [5:0] b;
                int lw, lr;
                bit e;
                pv = 4'(p); mv = 4'(m); b = 6'((p * 16 + m) * 5);
                do_reset();
                cfg(2'd0, {4'b0, mv});
                cfg(2'd2, {b, 2'b00});
                cfg(2'd1, 8'h01);
                dev_req = pv;
                cyc();
                dev_req = '0;
                e  = (pv & mv) != 0;
                lw = lowest(pv & mv);
                chk("R2/R3 irq after request", cpu_irq, e);
                cpu_ack = 1'b1;
                #1;
                chk("R6 oe on ack", vec_oe, e);
                chk("R4/R5 vector", vec, e ? {b, 2'(lw)} : 8'h00);
                cyc();
                cpu_ack = 1'b0;
                chk("R8 irq low after ack", cpu_irq, 0);
                rem = e ? (pv & ~(4'b1 << lw)) : pv;
                cfg(2'd0, 8'h0F);
                cfg(2'd1, 8'h01);
                chk("R3/R11 retained pending", cpu_irq, rem != 0);
                cpu_ack = 1'b1;
                #1;
                lr = lowest(rem);
                chk("R8 survivor vector", vec, (rem != 0) ? {b, 2'(lr)} : 8'h00);
                cyc();
                cpu_ack = 1'b0;
            end
        end

        // R7: enable off blocks request but keeps pending
        do_reset();
        cfg(2'd0, 8'h0F);
        dev_req = 4'b0100;
        cyc();
        dev_req = '0;
        chk("R7 irq blocked", cpu_irq, 0);
        cpu_ack = 1'b1;
        #1;
        chk("R7 oe blocked", vec_oe, 0);
        cyc();
        cpu_ack = 1'b0;
        cfg(2'd1, 8'h01);
        chk("R7 irq after enable", cpu_irq, 1);
        cpu_ack = 1'b1;
        #1;
        chk("R7 vector idx 2", vec, 8'h02);
        cyc();
        cpu_ack = 1'b0;

        // R9: new request in the clear cycle survives
        do_reset();
        cfg(2'd0, 8'h0F);
        cfg(2'd1, 8'h01);
        dev_req = 4'b0001;
        cyc();
        cpu_ack = 1'b1;
        cyc();
        cpu_ack = 1'b0;
        dev_req = '0;
        chk("R9 irq low (enable cleared)", cpu_irq, 0);
        cfg(2'd1, 8'h01);
        chk("R9 bit kept", cpu_irq, 1);
        cpu_ack = 1'b1;
        #1;
        chk("R9 vector idx 0", vec, 8'h00);
        chk("R9 oe", vec_oe, 1);
        cyc();
        cpu_ack = 1'b0;

        // R10: enable write beats the acknowledge clear
        do_reset();
        cfg(2'd0, 8'h0F);
        cfg(2'd1, 8'h01);
        cfg(2'd2, 8'hA8);
        dev_req = 4'b0011;
        cyc();
        dev_req = '0;
        cpu_ack = 1'b1;
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 8'h01;
        #1;
        chk("R10 first vector", vec, 8'hA8);
        cyc();
        cpu_ack = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd3; cfg_wdata = '0;
        chk("R10 irq stays", cpu_irq, 1);
        cfg(2'd3, 8'hFF);
        chk("R10 select 3 no effect", cpu_irq, 1);
        cpu_ack = 1'b1;
        #1;
        chk("R10 second vector", vec, 8'hA9);
        cyc();
        cpu_ack = 1'b0;
        chk("R10 irq low after last", cpu_irq, 0);

        summary();
    end

endmodule